// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. On any clock edge where a burst start is accepted, it captures the externally supplied address. After that, each clock with the advance input high steps the low address bits through a four-beat group. The upper address bits stay frozen until the next start.

Two start inputs are provided.
- The host-side start takes effect only while the chip enable is active.
- The controller-side start always takes effect.

A burst-order select, captured together with the address, picks between two orders:
- Linear order: the low bits count upward from the loaded value.
- Interleaved order: the low bits are the loaded value XOR the beat count.

Bursting is optional. A fresh address may be started on every clock with no lost cycle. The current address is presented every cycle directly from registered state.

Top module: `bas_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no start applied, `addr_out` is 0.
- R2: A clock edge with `hst_start`=1 and `chip_en`=1 makes `addr_out` equal the sampled `ext_addr` from the next cycle on, and restarts the beat count at 0.
- R3: A clock edge with `ctl_start`=1 loads `ext_addr` the same way, whatever the value of `chip_en`.
- R4: `hst_start` has no effect when `chip_en`=0. With no `ctl_start` and no `advance`, `addr_out` keeps its value.
- R5: When `hst_start` and `ctl_start` are both 1 on the same edge, exactly one load of `ext_addr` occurs and the beat count restarts at 0.
- R6: With `order_sel`=0 captured at load, beat n (n = 0..3) shows low two bits equal to (loaded low bits + n) mod 4.
- R7: With `order_sel`=1 captured at load, beat n shows low two bits equal to loaded low bits XOR n.
- R8: After beat 3, a further advance returns to beat 0 of the same four-word group. Bits above bit 1 never change except on a load.
- R9: With no accepted start and `advance`=0, `addr_out` holds its value.
- R10: A load on the same edge as `advance`=1 takes precedence; the new address appears at beat 0.
- R11: A different address may be loaded on every consecutive edge, each appearing one cycle after it is sampled.
- R12: The burst order is captured only at load. Changing `order_sel` during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External word address captured at a burst start |
| hst_start | input | 1 | Host-side burst start, honoured only with chip enable |
| ctl_start | input | 1 | Controller-side burst start, always honoured |
| chip_en | input | 1 | Chip enable qualifying the host-side start |
| advance | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |

## Verification
The assertions check three properties on every cycle:
- An accepted start shows the sampled address one cycle later.
- A quiet cycle leaves the address unchanged, and an ignored host start changes nothing.
- The upper bits move only on a load, and an advance always changes the low bits.

Only the bench scenarios can show the rest:
- The exact linear and interleaved beat sequences, including the wrap back to beat 0.
- Load taking priority over advance.
- The burst order being frozen at load time.
- The reset value.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } bas_order_e;

endpackage

// File: rtl/bas_load_ctrl.sv
module bas_load_ctrl (
    input  logic hst_start,
    input  logic ctl_start,
    input  logic chip_en,
    output logic load,
    output logic step_ok
);
    logic hst_ok;

    always_comb begin
        // host start needs the chip enable; controller start wins when both are set
        hst_ok  = hst_start && chip_en;
        load    = ctl_start || hst_ok;
        step_ok = !load;
    end
endmodule

// File: rtl/bas_beat_map.sv
module bas_beat_map
    import bas_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_low,
    input  logic [BEAT_W-1:0] beat,
    input  bas_order_e        order,
    output logic [BEAT_W-1:0] low_out
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;

    // one bit slice per position for the XOR form
    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
            assign xor_low[gi] = base_low[gi] ^ beat[gi];
        end
    endgenerate

    always_comb begin
        lin_low = base_low + beat;
        low_out = (order == ORD_XOR) ? xor_low : lin_low;
    end
endmodule

// File: rtl/bas_seq.sv
module bas_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              hst_start,
    input  logic              ctl_start,
    input  logic              chip_en,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BEAT_W-1:0] base_low;
        logic [BEAT_W-1:0] beat;
        bas_order_e        order;
    } bas_state_t;

    bas_state_t st_d, st_q;
    logic load, step_ok;
    logic [BEAT_W-1:0] low_now;

    bas_load_ctrl u_ld (
        .hst_start(hst_start),
        .ctl_start(ctl_start),
        .chip_en  (chip_en),
        .load     (load),
        .step_ok  (step_ok)
    );

    bas_beat_map #(.BEAT_W(BEAT_W)) u_map (
        .base_low(st_q.base_low),
        .beat    (st_q.beat),
        .order   (st_q.order),
        .low_out (low_now)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.hi       = ext_addr[ADDR_W-1:BEAT_W];
            st_d.base_low = ext_addr[BEAT_W-1:0];
            st_d.beat     = '0;
            st_d.order    = bas_order_e'(order_sel);
        end else if (step_ok && advance) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hi: '0, base_low: '0, beat: '0, order: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = {st_q.hi, low_now};
endmodule

// File: rtl/bas_seq_chk.sv
module bas_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              hst_start,
    input logic              ctl_start,
    input logic              chip_en,
    input logic              advance,
    input logic [ADDR_W-1:0] addr_out
);
    // R2 R3
    load_shows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hst_start && chip_en) || ctl_start) |=> addr_out == $past(ext_addr));

    // R9
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hst_start && chip_en) && !ctl_start && !advance) |=> $stable(addr_out));

    // R4
    gated_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_start && !chip_en && !ctl_start && !advance) |=> $stable(addr_out));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hst_start && chip_en) && !ctl_start)
        |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    // R6 R7
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hst_start && chip_en) && !ctl_start && advance)
        |=> addr_out[BEAT_W-1:0] != $past(addr_out[BEAT_W-1:0]));
endmodule

bind bas_seq bas_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .hst_start(hst_start),
    .ctl_start(ctl_start),
    .chip_en  (chip_en),
    .advance  (advance),
    .addr_out (addr_out)
);

// File: tb/sim_bas_seq.sv
module sim_bas_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic hst_start = 1'b0, ctl_start = 1'b0, chip_en = 1'b0;
    logic advance = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bas_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .hst_start(hst_start), .ctl_start(ctl_start), .chip_en(chip_en),
        .advance(advance), .order_sel(order_sel), .addr_out(addr_out)
    );

    task automatic chk(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (addr_out !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, return at next falling edge
    task automatic cyc(input logic hs, input logic cs, input logic ce,
                       input logic adv, input logic ord, input logic [AW-1:0] a);
        hst_start = hs; ctl_start = cs; chip_en = ce;
        advance = adv; order_sel = ord; ext_addr = a;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, '0);
    endtask

    function automatic logic [AW-1:0] lin(input logic [AW-1:0] b, input int n);
        return {b[AW-1:2], 2'((b[1:0] + n) % 4)};
    endfunction

    function automatic logic [AW-1:0] ilv(input logic [AW-1:0] b, input int n);
        return {b[AW-1:2], b[1:0] ^ 2'(n)};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in reset", '0);
        rst_n = 1'b1;
        idle();
        chk("R1 after reset", '0);
    endtask

    task automatic t_host_load();
        cyc(1, 0, 1, 0, 0, 20'hABCD6);
        chk("R2 host load", 20'hABCD6);
    endtask

    task automatic t_ce_gate();
        cyc(1, 0, 1, 0, 0, 20'h12341);
        cyc(1, 0, 0, 0, 0, 20'h77777);
        chk("R4 host start ignored", 20'h12341);
        idle();
        chk("R4 still held", 20'h12341);
    endtask

    task automatic t_ctl_load();
        cyc(0, 1, 0, 0, 0, 20'h0F0F3);
        chk("R3 ctl load ce low", 20'h0F0F3);
        cyc(0, 1, 1, 0, 0, 20'h00102);
        chk("R3 ctl load ce high", 20'h00102);
    endtask

    task automatic t_both();
        cyc(0, 1, 1, 0, 0, 20'h55550);
        cyc(0, 0, 0, 1, 0, '0);
        cyc(1, 1, 1, 0, 0, 20'h3A3A2);
        chk("R5 both starts", 20'h3A3A2);
        cyc(0, 0, 0, 1, 0, '0);
        chk("R5 beat restarted", lin(20'h3A3A2, 1));
    endtask

    task automatic t_linear();
        logic [AW-1:0] b = 20'hBEEF2;
        cyc(0, 1, 0, 0, 0, b);
        chk("R6 beat0", lin(b, 0));
        for (int n = 1; n < 4; n++) begin
            cyc(0, 0, 0, 1, 0, '0);
            chk($sformatf("R6 beat%0d", n), lin(b, n));
        end
        cyc(0, 0, 0, 1, 0, '0);
        chk("R8 wrap linear", lin(b, 0));
    endtask

    task automatic t_interleave();
        logic [AW-1:0] b = 20'h4C4C1;
        cyc(0, 1, 0, 0, 1, b);
        chk("R7 beat0", ilv(b, 0));
        for (int n = 1; n < 4; n++) begin
            cyc(0, 0, 0, 1, 1, '0);
            chk($sformatf("R7 beat%0d", n), ilv(b, n));
        end
        cyc(0, 0, 0, 1, 1, '0);
        chk("R8 wrap interleaved", ilv(b, 0));
    endtask

    task automatic t_hold();
        logic [AW-1:0] b = 20'h9999B;
        cyc(0, 1, 0, 0, 0, b);
        cyc(0, 0, 0, 1, 0, '0);
        cyc(0, 0, 1, 0, 0, 20'h11111);
        chk("R9 hold 1", lin(b, 1));
        cyc(0, 0, 0, 0, 1, 20'h22222);
        chk("R9 hold 2", lin(b, 1));
    endtask

    task automatic t_load_over_adv();
        cyc(0, 1, 0, 0, 0, 20'h60000);
        cyc(0, 0, 0, 1, 0, '0);
        cyc(1, 0, 1, 1, 0, 20'h7AB03);
        chk("R10 load beats advance", 20'h7AB03);
    endtask

    task automatic t_back2back();
        for (int i = 0; i < 5; i++) begin
            logic [AW-1:0] a = 20'(32'h1357 * (i + 1) + i);
            cyc(i % 2 == 0, i % 2 == 1, 1, 1, 0, a);
            chk($sformatf("R11 load %0d", i), a);
        end
    endtask

    task automatic t_order_latch();
        logic [AW-1:0] b = 20'hC0DE1;
        cyc(0, 1, 0, 0, 1, b);
        cyc(0, 0, 0, 1, 0, '0);
        chk("R12 stays interleaved 1", ilv(b, 1));
        cyc(0, 0, 0, 1, 0, '0);
        chk("R12 stays interleaved 2", ilv(b, 2));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: expired actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_host_load();
        t_ce_gate();
        t_ctl_load();
        t_both();
        t_linear();
        t_interleave();
        t_hold();
        t_load_over_adv();
        t_back2back();
        t_order_latch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule